// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers five interrupt sources in front of a small processor core and decides which one, if any, the core should take. One non-maskable emergency line, three maskable restart lines (high, middle and low) and one general request line are arbitrated under a fixed priority. The three restart lines each have a programmable mask, and a global enable gates all but the emergency line. The core marks the next-to-last clock of every instruction with a one-cycle `sample_pt` pulse. The block evaluates its sources only on that clock.

When a restart source or the emergency line wins, the block raises `take` for one cycle and presents the 16-bit restart address on `take_vec`. When the general request wins, it raises `ext_ack` instead. The core uses that strobe like a read to fetch an externally supplied opcode, and it does not advance its program counter. Any acceptance clears the global enable. Pushing the return address and branching remain the core's job.

A byte-wide configuration port writes the masks and the enable, clears the high-line edge latch, and reads back the masks, the enable and the raw pending state.

Top module: `vectored_irq_ctrl`

## Requirements
- R1: After reset `take` and `ext_ack` are low, all three restart masks read back as set and the global enable reads back as clear, so `cfg_rdata` equals 8'h07 while the lines are idle.
- R2: Priority from highest to lowest is emergency line, high restart line, middle restart line, low restart line, general request. On a sample clock, only the highest pending qualified source is accepted.
- R3: The emergency line is accepted whether or not the global enable is set and whatever the masks hold.
- R4: The emergency line is accepted only after a low-to-high transition that is still high on the sample clock. A line that stays high is not accepted a second time, and a pulse that ends before the sample clock is lost.
- R5: Sources are evaluated only on a clock where `sample_pt` is high. The outcome appears on `take`/`ext_ack` in the next cycle as a single-cycle pulse, and both stay low at all other times.
- R6: A restart line whose mask bit is set is never accepted, even with the global enable set. Mask bits are `cfg_wdata[0]` for the low line, `[1]` for the middle line and `[2]` for the high line, and they are applied when `cfg_wdata[3]` is 1.
- R7: Every acceptance clears the global enable. With the enable clear, no maskable or general source is accepted. A write with `cfg_wdata[6]`=1 loads the enable from `cfg_wdata[5]`.
- R8: Acceptance of the general request raises `ext_ack` with `take` low and `take_vec` zero.
- R9: Restart addresses are 16'h0024 for the emergency line, 16'h003C for the high line, 16'h0034 for the middle line and 16'h002C for the low line. `take_vec` is zero in cycles without `take`.
- R10: The high restart line is captured by a rising edge into a latch that stays set after the line falls. The latch clears on its own acceptance or on a write with `cfg_wdata[4]`=1.
- R11: The middle and low restart lines are level sensitive. If the line has fallen by the sample clock, it is not accepted.
- R12: `cfg_rdata` shows the masks in bits [2:0], the enable in bit 3, the low and middle line levels in bits 4 and 5, the high-line latch in bit 6 and the qualified emergency pending in bit 7.
- R13: Nothing records which source is in service. Once the enable is set again, a lower-priority source is accepted after a higher one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_line | input | 1 | Non-maskable emergency request |
| hi_line | input | 1 | High-priority restart request, edge captured |
| mid_line | input | 1 | Middle-priority restart request, level |
| lo_line | input | 1 | Low-priority restart request, level |
| ext_req | input | 1 | General request served with an external opcode |
| sample_pt | input | 1 | Core marks the next-to-last clock of an instruction |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Masks, enable and pending status |
| take | output | 1 | One-cycle restart acceptance pulse |
| take_vec | output | 16 | Restart address while `take` is high |
| ext_ack | output | 1 | One-cycle acknowledge for the general request |

## Verification
On every cycle, the assertions check that an output pulse only follows a sample clock and that `take` and `ext_ack` never coincide. They also check that the enable is clear in any cycle that shows an acceptance, that an accepted high line was unmasked and enabled one cycle earlier, and that an accepted emergency line was still high. The priority order, the exact addresses, the loss of short level pulses, the sticky high-line latch and its software clear, and re-entry of a lower source after a higher one only show up in the bench's scenarios. In those scenarios, each expected outcome is queued before the sample clock and compared when the pulse appears.

// File: rtl/pvic_pkg.sv
// Shared constants and helpers for the vectored interrupt controller.
// Source index order encodes priority: a higher index wins.
package pvic_pkg;
    localparam int NSRC  = 5;
    localparam int VEC_W = 16;
    localparam int CFG_W = 8;

    localparam int SRC_GEN  = 0;
    localparam int SRC_LO   = 1;
    localparam int SRC_MID  = 2;
    localparam int SRC_HI   = 3;
    localparam int SRC_TRAP = 4;

    localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_HI   = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_MID  = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LO   = 16'h002C;

    // Restart address for a one-hot grant; zero for the general request or none.
    function automatic logic [VEC_W-1:0] vec_of(input logic [NSRC-1:0] gnt);
        logic [VEC_W-1:0] v;
        v = '0;
        if (gnt[SRC_TRAP]) v = VEC_TRAP;
        if (gnt[SRC_HI])   v = VEC_HI;
        if (gnt[SRC_MID])  v = VEC_MID;
        if (gnt[SRC_LO])   v = VEC_LO;
        return v;
    endfunction
endpackage

// File: rtl/pvic_edge_cap.sv
// Rising-edge capture for one request line.
// LEVEL_QUAL=1: the capture is dropped whenever the line is low, and pending
//               needs the line still high (edge-and-level qualification).
// LEVEL_QUAL=0: the capture is sticky until cleared (pure edge latch).
// Assumes the line is already synchronous to clk. A new rising edge wins over clr.
module pvic_edge_cap #(
    parameter bit LEVEL_QUAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic cap_q;
    logic rise;

    assign rise = line & ~prev_q;

    // Remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= line;
    end

    generate
        if (LEVEL_QUAL) begin : g_qual
            // Arm on a rising edge, disarm on clear or when the line falls.
            always_ff @(posedge clk) begin
                if (!rst_n) cap_q <= 1'b0;
                else        cap_q <= (rise | (cap_q & ~clr)) & line;
            end
            assign pend = cap_q & line;
        end else begin : g_sticky
            // Latch a rising edge until cleared.
            always_ff @(posedge clk) begin
                if (!rst_n) cap_q <= 1'b0;
                else        cap_q <= rise | (cap_q & ~clr);
            end
            assign pend = cap_q;
        end
    endgenerate
endmodule

// File: rtl/pvic_pick.sv
// Fixed-priority selector: returns a one-hot grant of the highest set request.
// Purely combinational; higher index means higher priority.
module pvic_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // Scan upward so the last (highest) set request overrides lower ones.
    always_comb begin
        gnt = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) gnt = '0 | (N'(1) << i);
        end
    end
endmodule

// File: rtl/vectored_irq_ctrl.sv
// Vectored interrupt controller top.
// Qualifies five sources with masks and a global enable, picks the highest
// on the core's sample clock, and registers a one-cycle accept or acknowledge.
// Assumes all request lines and sample_pt are synchronous to clk.
module vectored_irq_ctrl
    import pvic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_line,
    input  logic             hi_line,
    input  logic             mid_line,
    input  logic             lo_line,
    input  logic             ext_req,
    input  logic             sample_pt,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             take,
    output logic [VEC_W-1:0] take_vec,
    output logic             ext_ack
);
    localparam int NMASK = 3;

    logic [NMASK-1:0] mask_q;
    logic             ien_q;
    logic             trap_pend;
    logic             hi_pend;
    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  gnt;
    logic             fire;
    logic             hi_clr;
    logic             take_q;
    logic             ack_q;
    logic [VEC_W-1:0] vec_q;

    assign fire   = sample_pt & (|gnt);
    assign hi_clr = (fire & gnt[SRC_HI]) | (cfg_wr & cfg_wdata[4]);

    pvic_edge_cap #(.LEVEL_QUAL(1'b1)) u_trap_cap (
        .clk(clk), .rst_n(rst_n), .line(nmi_line),
        .clr(fire & gnt[SRC_TRAP]), .pend(trap_pend)
    );

    pvic_edge_cap #(.LEVEL_QUAL(1'b0)) u_hi_cap (
        .clk(clk), .rst_n(rst_n), .line(hi_line),
        .clr(hi_clr), .pend(hi_pend)
    );

    // Qualify each source with its mask and the global enable.
    always_comb begin
        req           = '0;
        req[SRC_TRAP] = trap_pend;
        req[SRC_HI]   = hi_pend  & ~mask_q[2] & ien_q;
        req[SRC_MID]  = mid_line & ~mask_q[1] & ien_q;
        req[SRC_LO]   = lo_line  & ~mask_q[0] & ien_q;
        req[SRC_GEN]  = ext_req  & ien_q;
    end

    pvic_pick #(.N(NSRC)) u_pick (.req(req), .gnt(gnt));

    // Mask register: loaded only when the apply bit is set; all masked on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                     mask_q <= '1;
        else if (cfg_wr && cfg_wdata[3]) mask_q <= cfg_wdata[NMASK-1:0];
    end

    // Global enable: acceptance clears it ahead of any software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ien_q <= 1'b0;
        else if (fire)                   ien_q <= 1'b0;
        else if (cfg_wr && cfg_wdata[6]) ien_q <= cfg_wdata[5];
    end

    // Register the outcome so take/ext_ack are clean one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            ack_q  <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= fire & ~gnt[SRC_GEN];
            ack_q  <= fire &  gnt[SRC_GEN];
            vec_q  <= fire ? vec_of(gnt) : '0;
        end
    end

    assign take      = take_q;
    assign ext_ack   = ack_q;
    assign take_vec  = vec_q;
    assign cfg_rdata = {trap_pend, hi_pend, mid_line, lo_line, ien_q, mask_q};

    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && ext_ack)); // R8
    AST_PULSE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (take || ext_ack) |-> $past(sample_pt)); // R5
    AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (take || ext_ack) |-> !ien_q); // R7
    AST_HI_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_vec == VEC_HI) |-> $past(!mask_q[2] && ien_q)); // R6
    AST_TRAP_STILL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_vec == VEC_TRAP) |-> $past(nmi_line)); // R4
endmodule

// File: tb/tb_vectored_irq_ctrl.sv
// Scoreboard bench: the sample driver queues the expected outcome; a monitor
// compares it on the cycle after the sample clock and checks silence elsewhere.
module tb_vectored_irq_ctrl;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_line = 1'b0, hi_line = 1'b0, mid_line = 1'b0, lo_line = 1'b0, ext_req = 1'b0;
    logic        sample_pt = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        take, ext_ack;
    logic [15:0] take_vec;

    int checks = 0;
    int fails  = 0;
    logic mon_on = 1'b0;
    logic saw_sample = 1'b0;
    logic [17:0] exp_q[$];
    int          req_q[$];

    vectored_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .nmi_line(nmi_line), .hi_line(hi_line),
        .mid_line(mid_line), .lo_line(lo_line), .ext_req(ext_req),
        .sample_pt(sample_pt), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .take(take), .take_vec(take_vec), .ext_ack(ext_ack)
    );

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk) saw_sample <= sample_pt;

    // Monitor: compare queued expectations, else demand silence (R5).
    always @(negedge clk) begin
        if (mon_on) begin
            if (saw_sample) begin
                logic [17:0] e;
                int r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                checks++;
                if ({take, ext_ack, take_vec} !== e) begin
                    fails++;
                    $display("FAIL R%0d: take/ack/vec = %b/%b/%h expected %b/%b/%h",
                             r, take, ext_ack, take_vec, e[17], e[16], e[15:0]);
                end
            end else begin
                checks++;
                if (take || ext_ack || take_vec != 0) begin
                    fails++;
                    $display("FAIL R5: unsampled pulse take=%b ack=%b vec=%h expected 0/0/0000",
                             take, ext_ack, take_vec);
                end
            end
        end
    end

    task automatic sample_expect(input logic t, input logic a, input logic [15:0] v, input int r);
        @(negedge clk);
        exp_q.push_back({t, a, v});
        req_q.push_back(r);
        sample_pt = 1'b1;
        @(negedge clk);
        sample_pt = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic check_reg(input logic [7:0] exp, input int r);
        @(negedge clk);
        checks++;
        if (cfg_rdata !== exp) begin
            fails++;
            $display("FAIL R%0d: cfg_rdata = %h expected %h", r, cfg_rdata, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        mon_on = 1'b1;
        check_reg(8'h07, 1);                 // R1 reset state
        cfg_write(8'h60);                    // enable on, masks still set
        lo_line = 1; mid_line = 1; hi_line = 1;
        idle(2);
        check_reg(8'h7F, 12);                // R12 field layout
        sample_expect(0, 0, 16'h0000, 6);    // R6 masked lines refused
        cfg_write(8'h08);                    // unmask all
        sample_expect(1, 0, 16'h003C, 2);    // R2 high line first, R9
        check_reg(8'h30, 7);                 // R7 enable cleared, R10 latch cleared
        sample_expect(0, 0, 16'h0000, 7);    // R7 nothing while disabled
        cfg_write(8'h60);
        sample_expect(1, 0, 16'h0034, 2);    // R2 middle next
        cfg_write(8'h60);
        sample_expect(1, 0, 16'h0034, 11);   // R11 level still held
        mid_line = 0;
        cfg_write(8'h60);
        sample_expect(1, 0, 16'h002C, 9);    // R9 low address
        lo_line = 0;
        cfg_write(8'h60);
        sample_expect(0, 0, 16'h0000, 11);   // R11 level gone
        hi_line = 0;
        idle(1);
        hi_line = 1; idle(1); hi_line = 0;   // short pulse on the high line
        idle(3);
        sample_expect(1, 0, 16'h003C, 10);   // R10 latch held after line fell
        hi_line = 1; idle(1); hi_line = 0;
        cfg_write(8'h10);                    // software clear of the latch
        check_reg(8'h00, 10);                // R10 latch cleared
        cfg_write(8'h60);
        sample_expect(0, 0, 16'h0000, 10);   // R10 nothing after clear
        cfg_write(8'h0F);                    // mask all, enable off
        nmi_line = 1;
        idle(2);
        sample_expect(1, 0, 16'h0024, 3);    // R3 emergency bypasses masks/enable
        sample_expect(0, 0, 16'h0000, 4);    // R4 held level not re-accepted
        nmi_line = 0; idle(1);
        nmi_line = 1; idle(2); nmi_line = 0;
        sample_expect(0, 0, 16'h0000, 4);    // R4 pulse ended before sample
        cfg_write(8'h08);                    // unmask
        cfg_write(8'h60);
        lo_line = 1; mid_line = 1; ext_req = 1; hi_line = 1; nmi_line = 1;
        idle(2);
        sample_expect(1, 0, 16'h0024, 2);    // R2 emergency over everything
        nmi_line = 0;
        cfg_write(8'h60);
        sample_expect(1, 0, 16'h003C, 13);   // R13 lower source after higher
        cfg_write(8'h60);
        sample_expect(1, 0, 16'h0034, 2);
        mid_line = 0;
        cfg_write(8'h60);
        sample_expect(1, 0, 16'h002C, 2);
        lo_line = 0;
        cfg_write(8'h60);
        sample_expect(0, 1, 16'h0000, 8);    // R8 general request acknowledged
        check_reg(8'h40 & 8'h00, 7);         // R7 enable cleared after ack
        ext_req = 0; hi_line = 0;
        idle(4);                             // R5 monitor sees silence
        mon_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule